// File: doc/BRIEF.md
# Bit-Field Extract and Insert Unit

This block performs bit-field work on 32-bit data for an execution pipeline. A 2-bit opcode selects one of four operations. The operations are a sign-extending field read, a zero-extending field read, generation of a shifted value and mask pair, and a field merge. The field origin comes from the low bits of a position operand held in a register. The field length comes from a 5-bit immediate. Every operation finishes in one combinational pass and is captured in an output register.

An issuing stage raises `inValid` together with the opcode and operands. One clock later the unit raises `outValid` and presents the primary result. It also presents the secondary result, which only the mask-pair operation fills. The results keep their value while no operation is issued. A synchronous active-high reset clears them.

Top module: `bitfield_unit`

## Requirements
- R1: The field position is `posOperand[4:0]`. Bits 31..5 of `posOperand` never change any result.
- R2: Opcode 1 (zero-extending read) gives `(srcA >> pos)` with all bits at or above `widthImm` cleared. A width of 0 gives 0.
- R3: Opcode 0 (sign-extending read) takes the same `widthImm`-bit field as opcode 1. It then copies field bit `widthImm-1` into all bits above the field. A width of 0 gives 0.
- R4: No bit position wraps around. Field bits that would lie above bit 31 of `srcA` read as 0 in opcodes 0 and 1. Mask bits and shifted bits that would land above bit 31 are dropped in opcodes 2 and 3.
- R5: Opcode 2 (mask pair) gives a primary result of `srcB << pos`. Its secondary result is `widthImm` ones shifted left by `pos`.
- R6: Opcode 3 (field merge) returns `srcA`, except that the bits covered by the R5 mask come from `srcB << pos`. A width of 0 returns `srcA` unchanged.
- R7: The secondary result is 0 after every opcode other than 2.
- R8: `outValid` is high in exactly the cycle after a cycle with `inValid` high. Results for an operation appear together with that `outValid`.
- R9: While `rst` is high at a clock edge, `outValid`, `resultPrimary` and `resultSecondary` are cleared to 0 by that edge.
- R10: While `inValid` is low, both results hold their previous values, whatever the other inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| inValid | input | 1 | Qualifies the opcode and operands in this cycle |
| opSel | input | 2 | 0 signed read, 1 unsigned read, 2 mask pair, 3 field merge |
| srcA | input | 32 | Data holding the field (opcodes 0, 1, 3) |
| srcB | input | 32 | Data to be shifted into place (opcodes 2, 3) |
| posOperand | input | 32 | Field position, low 5 bits used |
| widthImm | input | 5 | Field width, 0 to 31 |
| outValid | output | 1 | Results are new this cycle |
| resultPrimary | output | 32 | Main result |
| resultSecondary | output | 32 | Mask output of opcode 2, else 0 |

## Verification
The mask-pair operation drives both result registers in the same cycle. Every other opcode must drive the secondary register back to zero in that same capture. The bench issues mask-pair operations back to back with other opcodes and random opcodes. This way a stale mask from the previous cycle would show up on the secondary output. A scoreboard judges each captured pair of results against a bitwise model, and it also judges the timing of `outValid`.

// File: rtl/bf_pkg.sv
package bf_pkg;

  typedef enum logic [1:0] {
    OP_SEXT     = 2'd0,
    OP_ZEXT     = 2'd1,
    OP_MASKPAIR = 2'd2,
    OP_INSERT   = 2'd3
  } bfOp_e;

  typedef struct packed {
    logic load;
    logic selSext;
    logic selZext;
    logic selMask;
    logic selIns;
  } bfStrobe_t;

endpackage

// File: rtl/bf_ctrl.sv
module bf_ctrl
  import bf_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       inValid,
  input  logic [1:0] opSel,
  output bfStrobe_t  strb,
  output logic       outValid
);

  bfOp_e opDec;

  always_comb begin
    opDec        = bfOp_e'(opSel);
    strb         = '0;
    strb.load    = inValid;
    strb.selSext = inValid && (opDec == OP_SEXT);
    strb.selZext = inValid && (opDec == OP_ZEXT);
    strb.selMask = inValid && (opDec == OP_MASKPAIR);
    strb.selIns  = inValid && (opDec == OP_INSERT);
  end

  always_ff @(posedge clk) begin
    if (rst) outValid <= 1'b0;
    else     outValid <= inValid;
  end

  // one select at most, and only with load
  assert_one_select_R8: assert property (@(posedge clk) disable iff (rst)
    $onehot0({strb.selSext, strb.selZext, strb.selMask, strb.selIns}));

  assert_valid_follows_R8: assert property (@(posedge clk) disable iff (rst)
    inValid |=> outValid);

  assert_no_spurious_valid_R8: assert property (@(posedge clk) disable iff (rst)
    !inValid |=> !outValid);

  assert_reset_clears_valid_R9: assert property (@(posedge clk)
    rst |=> !outValid);

endmodule

// File: rtl/bf_datapath.sv
module bf_datapath
  import bf_pkg::*;
#(
  parameter int DATA_W = 32,
  localparam int POS_W = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  bfStrobe_t         strb,
  input  logic [DATA_W-1:0] srcA,
  input  logic [DATA_W-1:0] srcB,
  input  logic [DATA_W-1:0] posOperand,
  input  logic [POS_W-1:0]  widthImm,
  output logic [DATA_W-1:0] resultPrimary,
  output logic [DATA_W-1:0] resultSecondary
);

  logic [POS_W-1:0]  bitPos;
  logic [POS_W-1:0]  signIdx;
  logic [DATA_W-1:0] onesLow;
  logic [DATA_W-1:0] fieldMask;
  logic [DATA_W-1:0] aShifted;
  logic [DATA_W-1:0] bShifted;
  logic [DATA_W-1:0] zextVal;
  logic [DATA_W-1:0] sextVal;
  logic [DATA_W-1:0] mergeVal;
  logic [DATA_W-1:0] nextPri;
  logic [DATA_W-1:0] nextSec;
  logic              signBit;

  assign bitPos = posOperand[POS_W-1:0];

  always_comb begin
    onesLow   = ~({DATA_W{1'b1}} << widthImm);
    fieldMask = onesLow << bitPos;
    aShifted  = srcA >> bitPos;
    bShifted  = srcB << bitPos;
    zextVal   = aShifted & onesLow;
    signIdx   = widthImm - 1'b1;
    signBit   = (widthImm != '0) && zextVal[signIdx];
    sextVal   = signBit ? (zextVal | ~onesLow) : zextVal;
    mergeVal  = (srcA & ~fieldMask) | (bShifted & fieldMask);
  end

  always_comb begin
    nextPri = '0;
    nextSec = '0;
    if (strb.selSext) nextPri = sextVal;
    if (strb.selZext) nextPri = zextVal;
    if (strb.selIns)  nextPri = mergeVal;
    if (strb.selMask) begin
      nextPri = bShifted;
      nextSec = fieldMask;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      resultPrimary   <= '0;
      resultSecondary <= '0;
    end else if (strb.load) begin
      resultPrimary   <= nextPri;
      resultSecondary <= nextSec;
    end
  end

  assert_sec_zero_R7: assert property (@(posedge clk) disable iff (rst)
    (strb.load && !strb.selMask) |=> (resultSecondary == '0));

  assert_merge_w0_R6: assert property (@(posedge clk) disable iff (rst)
    (strb.selIns && widthImm == '0) |=> (resultPrimary == $past(srcA)));

  assert_zext_w0_R2: assert property (@(posedge clk) disable iff (rst)
    (strb.selZext && widthImm == '0) |=> (resultPrimary == '0));

  assert_mask_count_R5: assert property (@(posedge clk) disable iff (rst)
    strb.selMask |=> ($countones(resultSecondary) <= int'($past(widthImm))));

  assert_mask_origin_R1: assert property (@(posedge clk) disable iff (rst)
    (strb.selMask && widthImm != '0) |=>
      resultSecondary[$past(posOperand) % DATA_W]);

  assert_hold_R10: assert property (@(posedge clk) disable iff (rst)
    !strb.load |=> ($stable(resultPrimary) && $stable(resultSecondary)));

  assert_reset_clears_R9: assert property (@(posedge clk)
    rst |=> (resultPrimary == '0 && resultSecondary == '0));

endmodule

// File: rtl/bitfield_unit.sv
module bitfield_unit
  import bf_pkg::*;
#(
  parameter int DATA_W = 32,
  localparam int POS_W = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              inValid,
  input  logic [1:0]        opSel,
  input  logic [DATA_W-1:0] srcA,
  input  logic [DATA_W-1:0] srcB,
  input  logic [DATA_W-1:0] posOperand,
  input  logic [POS_W-1:0]  widthImm,
  output logic              outValid,
  output logic [DATA_W-1:0] resultPrimary,
  output logic [DATA_W-1:0] resultSecondary
);

  bfStrobe_t strb;

  bf_ctrl u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .inValid  (inValid),
    .opSel    (opSel),
    .strb     (strb),
    .outValid (outValid)
  );

  bf_datapath #(.DATA_W(DATA_W)) u_dp (
    .clk             (clk),
    .rst             (rst),
    .strb            (strb),
    .srcA            (srcA),
    .srcB            (srcB),
    .posOperand      (posOperand),
    .widthImm        (widthImm),
    .resultPrimary   (resultPrimary),
    .resultSecondary (resultSecondary)
  );

endmodule

// File: tb/sim_bitfield_unit.sv
`timescale 1ns/1ps
module sim_bitfield_unit;

  logic        clk = 1'b0;
  logic        rst;
  logic        inValid;
  logic [1:0]  opSel;
  logic [31:0] srcA, srcB, posOperand;
  logic [4:0]  widthImm;
  logic        outValid;
  logic [31:0] resultPrimary, resultSecondary;

  int applied = 0;
  int miscompares = 0;
  logic [63:0] expQ[$];
  string       tagQ[$];

  always #4 clk = ~clk;

  bitfield_unit u0 (
    .clk(clk), .rst(rst), .inValid(inValid), .opSel(opSel),
    .srcA(srcA), .srcB(srcB), .posOperand(posOperand), .widthImm(widthImm),
    .outValid(outValid), .resultPrimary(resultPrimary),
    .resultSecondary(resultSecondary)
  );

  // bitwise reference built from the requirement text
  function automatic logic [63:0] model(input logic [1:0] op, input logic [31:0] a,
                                        input logic [31:0] b, input logic [31:0] posIn,
                                        input logic [4:0] w);
    int p = int'(posIn[4:0]);
    int wi = int'(w);
    logic [31:0] fld = '0, msk = '0, bsh = '0, pri = '0, sec = '0;
    for (int i = 0; i < 32; i++) begin
      if (i < wi && p + i < 32) fld[i] = a[p + i];
      if (i >= p && i < p + wi) msk[i] = 1'b1;
      if (i >= p) bsh[i] = b[i - p];
    end
    case (op)
      2'd0: begin
        pri = fld;
        if (wi > 0 && fld[wi-1])
          for (int i = 0; i < 32; i++) if (i >= wi) pri[i] = 1'b1;
      end
      2'd1: pri = fld;
      2'd2: begin pri = bsh; sec = msk; end
      default: for (int i = 0; i < 32; i++) pri[i] = msk[i] ? bsh[i] : a[i];
    endcase
    return {pri, sec};
  endfunction

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    applied++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic sendOp(input logic [1:0] op, input logic [31:0] a, input logic [31:0] b,
                        input logic [31:0] p, input logic [4:0] w, input string tag);
    @(negedge clk);
    inValid = 1'b1; opSel = op; srcA = a; srcB = b; posOperand = p; widthImm = w;
    expQ.push_back(model(op, a, b, p, w));
    tagQ.push_back(tag);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      inValid = 1'b0;
    end
  endtask

  // monitor: sample after the edge, compare with the queue head
  always @(posedge clk) begin
    #2;
    if (!rst && outValid) begin
      if (expQ.size() == 0) begin
        check("R8 outValid without issue", 64'd1, 64'd0);
      end else begin
        check(tagQ.pop_front(), {resultPrimary, resultSecondary}, expQ.pop_front());
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    miscompares++;
    $display("FAIL R8 watchdog expired actual=hung expected=done");
    $display("  == %0d vectors applied, %0d miscompares ==", applied, miscompares);
    $finish;
  end

  initial begin
    logic [63:0] held;
    rst = 1'b1; inValid = 1'b0; opSel = '0; srcA = '0; srcB = '0;
    posOperand = '0; widthImm = '0;
    repeat (3) @(negedge clk);
    check("R9 reset state", {31'd0, outValid, resultPrimary, resultSecondary}, '0);
    rst = 1'b0;

    // R2 unsigned reads
    sendOp(2'd1, 32'hDEAD_BEEF, 32'h0, 32'd4, 5'd8, "R2 zext mid");
    sendOp(2'd1, 32'hFFFF_FFFF, 32'h0, 32'd0, 5'd0, "R2 zext width zero");
    // R3 signed reads
    sendOp(2'd0, 32'h0000_0F00, 32'h0, 32'd8, 5'd4, "R3 sext negative");
    sendOp(2'd0, 32'h0000_0700, 32'h0, 32'd8, 5'd4, "R3 sext positive");
    sendOp(2'd0, 32'hFFFF_FFFF, 32'h0, 32'd5, 5'd0, "R3 sext width zero");
    // R4 fields running off the top
    sendOp(2'd0, 32'hF000_0000, 32'h0, 32'd28, 5'd8, "R4 sext past top");
    sendOp(2'd1, 32'hF000_0000, 32'h0, 32'd30, 5'd16, "R4 zext past top");
    sendOp(2'd2, 32'h0, 32'hFFFF_FFFF, 32'd28, 5'd8, "R4 mask past top");
    // R1 upper position bits ignored
    sendOp(2'd1, 32'h1234_5678, 32'h0, 32'hFFFF_FFE3, 5'd12, "R1 high pos bits");
    sendOp(2'd2, 32'h0, 32'h0000_00AB, 32'h8000_0024, 5'd6, "R1 mask high pos bits");
    // R5 / R6 / R7 back to back
    sendOp(2'd2, 32'h0, 32'h0000_0005, 32'd12, 5'd3, "R5 mask pair");
    sendOp(2'd3, 32'hFFFF_FFFF, 32'h0, 32'd4, 5'd8, "R6 merge zeros");
    sendOp(2'd2, 32'h0, 32'hFFFF_FFFF, 32'd0, 5'd31, "R5 wide mask");
    sendOp(2'd1, 32'hAAAA_AAAA, 32'h0, 32'd1, 5'd31, "R7 sec cleared after mask");
    sendOp(2'd3, 32'h1357_9BDF, 32'hFFFF_FFFF, 32'd9, 5'd0, "R6 merge width zero");
    sendOp(2'd3, 32'h0000_0000, 32'hFFFF_FFFF, 32'd20, 5'd20, "R6 merge past top");
    idle(3);

    // R10 hold with valid low
    @(negedge clk);
    held = {resultPrimary, resultSecondary};
    srcA = 32'h5555_5555; srcB = 32'h3333_3333; posOperand = 32'd7;
    widthImm = 5'd9; opSel = 2'd2;
    repeat (3) @(negedge clk);
    check("R10 hold while idle", {resultPrimary, resultSecondary}, held);
    check("R8 no valid while idle", {63'd0, outValid}, 64'd0);

    // random mix, back-to-back
    for (int k = 0; k < 400; k++) begin
      logic [1:0] op = 2'($urandom_range(0, 3));
      sendOp(op, $urandom, $urandom, $urandom, 5'($urandom_range(0, 31)),
             op == 2'd2 ? "R5 random" : (op == 2'd3 ? "R6 random" : "R7 random"));
      if (k % 37 == 0) idle(1);
    end
    idle(3);
    check("R8 all issued results seen", 64'(expQ.size()), 64'd0);

    // R9 reset mid-run
    sendOp(2'd1, 32'hFFFF_FFFF, 32'h0, 32'd0, 5'd16, "R2 before reset");
    @(negedge clk);
    inValid = 1'b0; rst = 1'b1;
    @(negedge clk);
    check("R9 reset clears results", {31'd0, outValid, resultPrimary, resultSecondary}, '0);
    rst = 1'b0;
    idle(2);

    $display("  == %0d vectors applied, %0d miscompares ==", applied, miscompares);
    $finish;
  end

endmodule